// File: doc/BRIEF.md
# UART Error Status and Interrupt Unit

This unit keeps the sticky receive and transmit error flags of a serial port together with the receiver-enable state, and drives that port's transmit, receive and error interrupt requests. The receiver sends single-cycle error strobes: parity, framing, receive overrun and transmit overrun. The FIFOs send single-cycle transmit and receive event strobes and a transmit-room level. The unit turns these into flags, pending bits and gated requests. Error detection and the FIFOs themselves sit outside the unit.

Software reaches the unit through a plain register port. The port takes a one-cycle write strobe and gives a combinational read of whichever address is presented. A mode register enables each error class. A read-only state register reports the flags. A write-only action register clears flags or switches the receiver on or off one bit at a time, so no read-modify-write sequence is needed. A pending register is cleared by writing ones, and an enable register masks the requests. No data stream passes through the unit, so it has no valid/ready handshake and no back-pressure. Every pin is a plain control or status signal. A write takes effect at the clock edge that samples it.

Register offsets are: mode 0x00, state 0x04, action 0x08, request enable 0x0C and pending 0x10. Any other offset reads zero and ignores writes.

Top module: `uart_err_irq_unit`

## Requirements
- R1: After reset, every register reads zero, rx_enabled is 0, and all three interrupt outputs are 0.
- R2: Mode register bits 16 (parity check), 17 (framing check), 19 (receive overrun check) and 20 (transmit overrun check) are stored by a write and read back. All other mode bits read as zero.
- R3: A strobe sets its flag in the state register at the next clock edge only when the matching mode bit is 1. The state bits are parity 16, framing 17, receive overrun 19 and transmit overrun 20, each using the same position as its mode bit.
- R4: A write of 1 to action bit 2, 3, 5 or 6 clears the parity, framing, receive overrun or transmit overrun flag. Action bits written 0 change nothing, and writes to the state register change nothing.
- R5: When an enabled error strobe and a clear of the same flag arrive in the same cycle, the flag ends up set.
- R6: Action bit 1 turns the receiver on and action bit 0 turns it off. When both are written as 1, bit 1 wins. The state is shown on state bit 0 and on rx_enabled.
- R7: The action register always reads zero.
- R8: Pending bit 0 is set by tx_evt, bit 1 by rx_evt, and bit 2 by any flag capture. Writing 1 to a pending bit clears it. An event in the same cycle as the clear leaves the bit set.
- R9: irq_tx = (pending 0 AND enable 0) OR (txbuf_room AND enable 3), and irq_rx = pending 1 AND enable 1. The enable register holds bits 3:0.
- R10: irq_err equals enable bit 2 AND the OR of the four error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| par_err_stb | input | 1 | Parity error strobe |
| frm_err_stb | input | 1 | Framing error strobe |
| rx_ovr_stb | input | 1 | Receive overrun strobe |
| tx_ovr_stb | input | 1 | Transmit overrun strobe |
| tx_evt | input | 1 | Transmit FIFO event strobe |
| rx_evt | input | 1 | Receive FIFO event strobe |
| txbuf_room | input | 1 | Transmit buffer has room (level) |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Error interrupt request |
| rx_enabled | output | 1 | Receiver enable state |

## Verification
Directed sequences come first.
- Strobes arrive with checking disabled and then enabled, which separates gated capture from ungated capture.
- Each clear bit is written alone, which shows that only one flag responds to it.
- A strobe and a clear of the same flag, and an event and a pending clear, land in the same cycle, which exposes the wrong priority.
- Both receiver bits are written together, which settles which one wins.

A long phase of random writes to every offset, including unmapped ones and the read-only state register, then runs with random strobes. A behavioural model is compared against the design every cycle, which catches wrong bit positions, leaking mask bits and ignored writes that have effects.

// File: rtl/uesi_pkg.sv
package uesi_pkg;
  localparam int OFS_MODE   = 'h00;
  localparam int OFS_STATE  = 'h04;
  localparam int OFS_ACTION = 'h08;
  localparam int OFS_IREN   = 'h0C;
  localparam int OFS_IRPEND = 'h10;

  localparam int NUM_FLAGS = 4;
  localparam int NUM_PEND  = 3;
  localparam int NUM_EN    = 4;

  localparam int IRQ_TX  = 0;
  localparam int IRQ_RX  = 1;
  localparam int IRQ_ERR = 2;
  localparam int IRQ_TXB = 3;

  localparam int RXEN_STATE_POS = 0;
  localparam int RXEN_OFF_POS   = 0;
  localparam int RXEN_ON_POS    = 1;

  // flag order: 0 parity, 1 framing, 2 receive overrun, 3 transmit overrun
  function automatic int flag_pos(int i);
    case (i)
      0:       return 16;
      1:       return 17;
      2:       return 19;
      default: return 20;
    endcase
  endfunction

  function automatic int clr_pos(int i);
    case (i)
      0:       return 2;
      1:       return 3;
      2:       return 5;
      default: return 6;
    endcase
  endfunction
endpackage

// File: rtl/uesi_flag_bank.sv
module uesi_flag_bank #(
  parameter int NF = uesi_pkg::NUM_FLAGS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] err_stb,
  input  logic [NF-1:0] chk_en,
  input  logic [NF-1:0] clr_req,
  output logic [NF-1:0] flags,
  output logic          captured,
  output logic          any_flag
);
  logic [NF-1:0] hit;

  assign hit      = err_stb & chk_en;
  assign captured = |hit;
  assign any_flag = |flags;

  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags[i] <= 1'b0;
      else if (hit[i])     flags[i] <= 1'b1;
      else if (clr_req[i]) flags[i] <= 1'b0;
    end

    // R5: a capture wins over a clear in the same cycle
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      err_stb[i] && chk_en[i] |=> flags[i]);
    // R4: clear without capture empties the flag
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req[i] && !(err_stb[i] && chk_en[i]) |=> !flags[i]);
    // R3: disabled checking never raises a clear flag
    a_r3_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_en[i] && !flags[i] |=> !flags[i]);
  end
endmodule

// File: rtl/uesi_regif.sv
module uesi_regif #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int NF     = uesi_pkg::NUM_FLAGS,
  parameter int NP     = uesi_pkg::NUM_PEND,
  parameter int NE     = uesi_pkg::NUM_EN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NF-1:0]     flags,
  input  logic [NP-1:0]     pend,
  output logic [DATA_W-1:0] rdata,
  output logic [NF-1:0]     chk_en,
  output logic [NF-1:0]     clr_req,
  output logic [NP-1:0]     w1c,
  output logic [NE-1:0]     irq_en,
  output logic              rx_on
);
  import uesi_pkg::*;

  localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_STATE  = ADDR_W'(OFS_STATE);
  localparam logic [ADDR_W-1:0] A_ACTION = ADDR_W'(OFS_ACTION);
  localparam logic [ADDR_W-1:0] A_IREN   = ADDR_W'(OFS_IREN);
  localparam logic [ADDR_W-1:0] A_IRPEND = ADDR_W'(OFS_IRPEND);

  logic sel_mode, sel_act, sel_en, sel_pend;
  logic unused_wdata;

  assign sel_mode = wr_en && (addr == A_MODE);
  assign sel_act  = wr_en && (addr == A_ACTION);
  assign sel_en   = wr_en && (addr == A_IREN);
  assign sel_pend = wr_en && (addr == A_IRPEND);
  assign unused_wdata = ^wdata;

  for (genvar i = 0; i < NF; i++) begin : g_mode
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        chk_en[i] <= 1'b0;
      else if (sel_mode) chk_en[i] <= wdata[flag_pos(i)];
    end
    assign clr_req[i] = sel_act && wdata[clr_pos(i)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             rx_on <= 1'b0;
    else if (sel_act && wdata[RXEN_ON_POS])  rx_on <= 1'b1;
    else if (sel_act && wdata[RXEN_OFF_POS]) rx_on <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_en <= '0;
    else if (sel_en) irq_en <= wdata[NE-1:0];
  end

  assign w1c = sel_pend ? wdata[NP-1:0] : '0;

  always_comb begin
    rdata = '0;
    case (addr)
      A_MODE: begin
        for (int i = 0; i < NF; i++) rdata[flag_pos(i)] = chk_en[i];
      end
      A_STATE: begin
        for (int i = 0; i < NF; i++) rdata[flag_pos(i)] = flags[i];
        rdata[RXEN_STATE_POS] = rx_on;
      end
      A_IREN:   rdata[NE-1:0] = irq_en;
      A_IRPEND: rdata[NP-1:0] = pend;
      default:  rdata = '0;
    endcase
  end

  // R6: the on bit wins over the off bit
  a_r6_rx_on: assert property (@(posedge clk) disable iff (!rst_n)
    sel_act && wdata[RXEN_ON_POS] |=> rx_on);
  a_r6_rx_off: assert property (@(posedge clk) disable iff (!rst_n)
    sel_act && wdata[RXEN_OFF_POS] && !wdata[RXEN_ON_POS] |=> !rx_on);
  // R2: mode bits hold without a mode write
  a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_mode |=> $stable(chk_en));
  // R9: enables hold without an enable write
  a_r9_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_en |=> $stable(irq_en));
endmodule

// File: rtl/uesi_irq_gate.sv
module uesi_irq_gate #(
  parameter int NP = uesi_pkg::NUM_PEND,
  parameter int NE = uesi_pkg::NUM_EN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] evt,
  input  logic [NP-1:0] w1c,
  input  logic [NE-1:0] irq_en,
  input  logic          err_any,
  input  logic          txbuf_room,
  output logic [NP-1:0] pend,
  output logic          irq_tx,
  output logic          irq_rx,
  output logic          irq_err
);
  import uesi_pkg::*;

  for (genvar i = 0; i < NP; i++) begin : g_pend
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend[i] <= 1'b0;
      else if (evt[i]) pend[i] <= 1'b1;
      else if (w1c[i]) pend[i] <= 1'b0;
    end

    // R8: event wins over a clear in the same cycle
    a_r8_evt_wins: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> pend[i]);
    a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      w1c[i] && !evt[i] |=> !pend[i]);
  end

  assign irq_tx  = (pend[IRQ_TX] & irq_en[IRQ_TX]) | (txbuf_room & irq_en[IRQ_TXB]);
  assign irq_rx  = pend[IRQ_RX] & irq_en[IRQ_RX];
  assign irq_err = err_any & irq_en[IRQ_ERR];

  // R10: no error request while its enable is off
  a_r10_err_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en[IRQ_ERR] |-> !irq_err);
  // R9: no transmit or receive request with all enables off
  a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en == '0 |-> !irq_tx && !irq_rx);
endmodule

// File: rtl/uart_err_irq_unit.sv
module uart_err_irq_unit #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              par_err_stb,
  input  logic              frm_err_stb,
  input  logic              rx_ovr_stb,
  input  logic              tx_ovr_stb,
  input  logic              tx_evt,
  input  logic              rx_evt,
  input  logic              txbuf_room,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_err,
  output logic              rx_enabled
);
  import uesi_pkg::*;

  localparam int NF = NUM_FLAGS;
  localparam int NP = NUM_PEND;
  localparam int NE = NUM_EN;

  logic [NF-1:0] stb, chk_en, clr_req, flags;
  logic [NP-1:0] w1c, pend, evt;
  logic [NE-1:0] irq_en;
  logic          captured, any_flag;

  assign stb = {tx_ovr_stb, rx_ovr_stb, frm_err_stb, par_err_stb};
  assign evt = {captured, rx_evt, tx_evt};

  uesi_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NF(NF), .NP(NP), .NE(NE)) u_regif (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .flags(flags), .pend(pend), .rdata(reg_rdata), .chk_en(chk_en),
    .clr_req(clr_req), .w1c(w1c), .irq_en(irq_en), .rx_on(rx_enabled)
  );

  uesi_flag_bank #(.NF(NF)) u_flags (
    .clk(clk), .rst_n(rst_n), .err_stb(stb), .chk_en(chk_en), .clr_req(clr_req),
    .flags(flags), .captured(captured), .any_flag(any_flag)
  );

  uesi_irq_gate #(.NP(NP), .NE(NE)) u_irq (
    .clk(clk), .rst_n(rst_n), .evt(evt), .w1c(w1c), .irq_en(irq_en),
    .err_any(any_flag), .txbuf_room(txbuf_room), .pend(pend),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  // R1: interrupts quiet right after reset release
  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq_tx && !irq_rx && !irq_err);
  // R3: an enabled strobe raises the error request when enabled
  a_r3_err_req: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stb & chk_en)) && irq_en[IRQ_ERR] && !(reg_wr && reg_addr == ADDR_W'(OFS_IREN)) |=> irq_err);
endmodule

// File: tb/test_uart_err_irq_unit.sv
module test_uart_err_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        par_err_stb = 0, frm_err_stb = 0, rx_ovr_stb = 0, tx_ovr_stb = 0;
  logic        tx_evt = 0, rx_evt = 0, txbuf_room = 0;
  logic        irq_tx, irq_rx, irq_err, rx_enabled;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  uart_err_irq_unit i_uart_err_irq_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .par_err_stb(par_err_stb),
    .frm_err_stb(frm_err_stb), .rx_ovr_stb(rx_ovr_stb), .tx_ovr_stb(tx_ovr_stb),
    .tx_evt(tx_evt), .rx_evt(rx_evt), .txbuf_room(txbuf_room),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err), .rx_enabled(rx_enabled)
  );

  // behavioural reference model
  bit [3:0] m_mode, m_flag, m_en;
  bit [2:0] m_pend;
  bit       m_rxen;
  bit [3:0] cap;
  bit       act_w;
  bit [2:0] pclr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode <= 0; m_flag <= 0; m_en <= 0; m_pend <= 0; m_rxen <= 0;
    end else begin
      cap   = {tx_ovr_stb, rx_ovr_stb, frm_err_stb, par_err_stb} & m_mode;
      act_w = reg_wr && reg_addr == 8'h08;
      pclr  = (reg_wr && reg_addr == 8'h10) ? reg_wdata[2:0] : 3'b000;
      if (reg_wr && reg_addr == 8'h00)
        m_mode <= {reg_wdata[20], reg_wdata[19], reg_wdata[17], reg_wdata[16]};
      if (reg_wr && reg_addr == 8'h0C) m_en <= reg_wdata[3:0];
      m_flag[0] <= (m_flag[0] && !(act_w && reg_wdata[2])) || cap[0];
      m_flag[1] <= (m_flag[1] && !(act_w && reg_wdata[3])) || cap[1];
      m_flag[2] <= (m_flag[2] && !(act_w && reg_wdata[5])) || cap[2];
      m_flag[3] <= (m_flag[3] && !(act_w && reg_wdata[6])) || cap[3];
      if (act_w && reg_wdata[1])      m_rxen <= 1'b1;
      else if (act_w && reg_wdata[0]) m_rxen <= 1'b0;
      m_pend <= (m_pend & ~pclr) | {|cap, rx_evt, tx_evt};
    end
  end

  function automatic logic [31:0] m_read(logic [7:0] a);
    logic [31:0] v = 32'h0;
    case (a)
      8'h00: begin v[16] = m_mode[0]; v[17] = m_mode[1]; v[19] = m_mode[2]; v[20] = m_mode[3]; end
      8'h04: begin v[16] = m_flag[0]; v[17] = m_flag[1]; v[19] = m_flag[2]; v[20] = m_flag[3]; v[0] = m_rxen; end
      8'h0C: v[3:0] = m_en;
      8'h10: v[2:0] = m_pend;
      default: v = 32'h0;
    endcase
    return v;
  endfunction

  function automatic string tag_for(logic [7:0] a);
    case (a)
      8'h00: return "R2";
      8'h04: return "R3";
      8'h08: return "R7";
      8'h0C: return "R9";
      8'h10: return "R8";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R9 irq_tx", {31'h0, irq_tx}, {31'h0, (m_pend[0] & m_en[0]) | (txbuf_room & m_en[3])});
      chk("R9 irq_rx", {31'h0, irq_rx}, {31'h0, m_pend[1] & m_en[1]});
      chk("R10 irq_err", {31'h0, irq_err}, {31'h0, m_en[2] & (|m_flag)});
      chk("R6 rx_enabled", {31'h0, rx_enabled}, {31'h0, m_rxen});
      chk(tag_for(reg_addr), reg_rdata, m_read(reg_addr));
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
    step();
  endtask

  initial begin
    #(8 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    // R1 reset state
    rd(8'h00, 0, "R1 mode"); rd(8'h04, 0, "R1 state");
    rd(8'h0C, 0, "R1 enable"); rd(8'h10, 0, "R1 pending");
    chk("R1 irqs", {29'h0, irq_tx, irq_rx, irq_err}, 0);

    // R3 strobe with checking off is ignored
    par_err_stb = 1; frm_err_stb = 1; step(); par_err_stb = 0; frm_err_stb = 0;
    rd(8'h04, 0, "R3 gated off"); rd(8'h10, 0, "R3 no err pending");

    // R2 mode bits
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, 32'h001B_0000, "R2 mode mask");
    wr(8'h00, 32'h0001_0000); rd(8'h00, 32'h0001_0000, "R2 mode parity only");
    frm_err_stb = 1; step(); frm_err_stb = 0;
    rd(8'h04, 0, "R3 framing disabled");
    wr(8'h00, 32'h001B_0000);

    // R3 capture, R10 error request
    par_err_stb = 1; step(); par_err_stb = 0;
    rd(8'h04, 32'h0001_0000, "R3 parity set");
    rd(8'h10, 32'h4, "R8 err pending");
    chk("R10 masked", {31'h0, irq_err}, 0);
    wr(8'h0C, 32'h4);
    @(negedge clk); chk("R10 irq_err on", {31'h0, irq_err}, 1); step();

    // R4 ignored writes and selective clear
    wr(8'h04, 32'h0);  rd(8'h04, 32'h0001_0000, "R4 state read-only");
    wr(8'h08, 32'h0);  rd(8'h04, 32'h0001_0000, "R4 zero action no effect");
    wr(8'h08, 32'h8);  rd(8'h04, 32'h0001_0000, "R4 framing clear spares parity");
    wr(8'h08, 32'h4);  rd(8'h04, 32'h0, "R4 parity cleared");
    rx_ovr_stb = 1; tx_ovr_stb = 1; step(); rx_ovr_stb = 0; tx_ovr_stb = 0;
    rd(8'h04, 32'h0018_0000, "R3 overrun flags");
    wr(8'h08, 32'h20); rd(8'h04, 32'h0010_0000, "R4 rx overrun cleared");
    wr(8'h08, 32'h40); rd(8'h04, 32'h0, "R4 tx overrun cleared");
    @(negedge clk); chk("R10 irq_err off", {31'h0, irq_err}, 0); step();

    // R5 set wins
    frm_err_stb = 1; reg_wr = 1; reg_addr = 8'h08; reg_wdata = 32'h8; step();
    frm_err_stb = 0; reg_wr = 0; reg_wdata = 0;
    rd(8'h04, 32'h0002_0000, "R5 set wins");
    wr(8'h08, 32'h8);

    // R6 receiver enable, R7 action reads zero
    wr(8'h08, 32'h2); rd(8'h04, 32'h1, "R6 rx on");
    wr(8'h08, 32'h1); rd(8'h04, 32'h0, "R6 rx off");
    wr(8'h08, 32'h3); rd(8'h04, 32'h1, "R6 both on wins");
    rd(8'h08, 32'h0, "R7 action reads zero");

    // R8 pending, R9 gating
    wr(8'h10, 32'h7); rd(8'h10, 32'h0, "R8 w1c all");
    tx_evt = 1; step(); tx_evt = 0;
    rd(8'h10, 32'h1, "R8 tx pending");
    chk("R9 tx masked", {31'h0, irq_tx}, 0);
    wr(8'h0C, 32'h3);
    @(negedge clk); chk("R9 tx request", {31'h0, irq_tx}, 1); step();
    rx_evt = 1; reg_wr = 1; reg_addr = 8'h10; reg_wdata = 32'h3; step();
    rx_evt = 0; reg_wr = 0; reg_wdata = 0;
    rd(8'h10, 32'h2, "R8 event wins over w1c");
    wr(8'h10, 32'h2);
    wr(8'h0C, 32'h8); txbuf_room = 1;
    @(negedge clk); chk("R9 txbuf request", {31'h0, irq_tx}, 1); step();
    txbuf_room = 0;
    @(negedge clk); chk("R9 txbuf gone", {31'h0, irq_tx}, 0); step();

    // random phase against the model
    for (int k = 0; k < 600; k++) begin
      reg_wr    = ($urandom % 3) == 0;
      reg_addr  = 8'(4 * ($urandom % 6));
      reg_wdata = $urandom;
      par_err_stb = ($urandom % 6) == 0;
      frm_err_stb = ($urandom % 6) == 0;
      rx_ovr_stb  = ($urandom % 6) == 0;
      tx_ovr_stb  = ($urandom % 6) == 0;
      tx_evt      = ($urandom % 5) == 0;
      rx_evt      = ($urandom % 5) == 0;
      txbuf_room  = ($urandom % 2) == 0;
      step();
    end
    reg_wr = 0;
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule